// File: doc/BRIEF.md
# Pipelined Rank Order Filter

This block picks the element of a chosen rank from a window of N unsigned M-bit samples, and it delivers one result on every clock. The selection runs one bit at a time, from the most significant bit down. To reach full rate, the M bit steps are laid out as M pipeline stages, so a new window can enter on every cycle.

For each window, every stage keeps two sticky flags per sample. One flag marks a sample already known to be larger than the result, and the other marks a sample already known to be smaller. From these flags the stage forms an effective bit per sample and counts the ones among them. The result bit is set when that count reaches the requested rank k. The samples, the flags, the rank and the result bits found so far all move with the window from stage to stage.

A rank of 1 returns the largest sample, a rank of N returns the smallest, and (N+1)/2 returns the median for odd N. Each window carries its own rank, so the rank can change from one window to the next. Cycles with valid low travel through the pipeline as empty slots.

Top module: `rank_order_pipe`

## Requirements
- R1: A window accepted with `valid_i` high in cycle c yields `valid_o` high in cycle c+M (M clock edges later), and each accepted window produces exactly one output.
- R2: For rank k in 1..N, `value_o` equals the k-th largest of the N samples, with equal samples counted separately. Sample j occupies `samples_i[j*M +: M]`, and the samples are unsigned.
- R3: Rank 1 returns the maximum of the window.
- R4: Rank N returns the minimum of the window.
- R5: Rank (N+1)/2 returns the median for odd N.
- R6: The rank is captured with its own window. Changing `rank_i` between consecutive windows changes only the windows that carry the new value.
- R7: Windows presented on consecutive cycles leave on consecutive cycles, in arrival order, with no gaps.
- R8: A cycle with `valid_i` low produces a cycle with `valid_o` low M cycles later. Windows on either side of such a cycle keep their correct results.
- R9: While `rst_ni` is low, `valid_o` is low. Windows in flight when reset is asserted never appear at the output, and a window accepted after reset is processed normally.
- R10: Rank 0 returns all ones. A rank greater than N returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; clears all stage valid bits |
| valid_i | input | 1 | Window present this cycle |
| samples_i | input | N*M | N unsigned samples; sample j at bits j*M +: M |
| rank_i | input | clog2(N+1) | Rank k for this window (1 = largest) |
| valid_o | output | 1 | Ranked result present |
| value_o | output | M | Ranked result |

## Verification
The hardest case to reach from the ports is a full pipeline with windows that differ in both rank and data on every cycle. Bubbles or a reset arriving at the same time as a full pipeline make this harder still. The bench therefore streams long back-to-back runs in which the rank changes on every window, interleaves empty cycles with live windows, and drops reset while several windows are still in flight. Windows full of ties are also applied, so that the count lands exactly on k at several bit positions; this is where a wrong comparison or a wrong flag update would show.

// File: rtl/rof_pkg.sv
package rof_pkg;
  function automatic int unsigned rank_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rof_cell.sv
// Per-sample bit update: effective bit from sticky flags, then flag update
// once the stage has decided the result bit.
module rof_cell (
  input  logic bit_i,
  input  logic gt_i,
  input  logic lt_i,
  input  logic res_i,
  output logic eff_o,
  output logic gt_o,
  output logic lt_o
);
  assign eff_o = gt_i | (~lt_i & bit_i);
  assign gt_o  = gt_i | (~lt_i & bit_i & ~res_i);
  assign lt_o  = lt_i | (~gt_i & ~bit_i & res_i);
endmodule

// File: rtl/rof_popcount.sv
module rof_popcount #(
  parameter int unsigned N  = 5,
  parameter int unsigned CW = 3
) (
  input  logic [N-1:0]  bits_i,
  output logic [CW-1:0] count_o
);
  always_comb begin
    count_o = '0;
    for (int j = 0; j < N; j++) count_o = count_o + CW'(bits_i[j]);
  end
endmodule

// File: rtl/rank_order_pipe.sv
module rank_order_pipe import rof_pkg::*; #(
  parameter  int unsigned N  = 5,
  parameter  int unsigned M  = 8,
  localparam int unsigned KW = rank_width(N)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [N*M-1:0] samples_i,
  input  logic [KW-1:0]  rank_i,
  output logic           valid_o,
  output logic [M-1:0]   value_o
);

  for (genvar s = 0; s < M; s++) begin : g_stg
    localparam int unsigned B = M - 1 - s;  // bit examined here

    logic [N-1:0][B:0] smp_in;
    logic [N-1:0]      gt_in, lt_in, eff, gt_nx, lt_nx;
    logic [KW-1:0]     k_in, cnt;
    logic              vld_in, res_bit;
    logic              vld_q;
    logic [s:0]        res_q;

    if (s == 0) begin : g_head
      assign smp_in = samples_i;
      assign gt_in  = '0;
      assign lt_in  = '0;
      assign k_in   = rank_i;
      assign vld_in = valid_i;
    end else begin : g_link
      assign smp_in = g_stg[s-1].g_fwd.smp_q;
      assign gt_in  = g_stg[s-1].g_fwd.gt_q;
      assign lt_in  = g_stg[s-1].g_fwd.lt_q;
      assign k_in   = g_stg[s-1].g_fwd.k_q;
      assign vld_in = g_stg[s-1].vld_q;
    end

    for (genvar j = 0; j < N; j++) begin : g_cell
      rof_cell u_cell (
        .bit_i (smp_in[j][B]),
        .gt_i  (gt_in[j]),
        .lt_i  (lt_in[j]),
        .res_i (res_bit),
        .eff_o (eff[j]),
        .gt_o  (gt_nx[j]),
        .lt_o  (lt_nx[j])
      );
    end

    rof_popcount #(.N(N), .CW(KW)) u_cnt (
      .bits_i  (eff),
      .count_o (cnt)
    );

    assign res_bit = (cnt >= k_in);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vld_q <= 1'b0;
      else         vld_q <= vld_in;
    end

    if (s == 0) begin : g_res_first
      always_ff @(posedge clk_i) begin
        if (vld_in) res_q <= res_bit;
      end
    end else begin : g_res_next
      always_ff @(posedge clk_i) begin
        if (vld_in) res_q <= {g_stg[s-1].res_q, res_bit};
      end
    end

    // Only bits still undecided travel on; the stored width shrinks per stage.
    if (B > 0) begin : g_fwd
      logic [N-1:0][B-1:0] smp_q;
      logic [N-1:0]        gt_q, lt_q;
      logic [KW-1:0]       k_q;
      always_ff @(posedge clk_i) begin
        if (vld_in) begin
          for (int j = 0; j < N; j++) smp_q[j] <= smp_in[j][B-1:0];
          gt_q <= gt_nx;
          lt_q <= lt_nx;
          k_q  <= k_in;
        end
      end
    end else begin : g_tail
      logic unused_flags;
      assign unused_flags = ^{gt_nx, lt_nx};
    end
  end

  assign valid_o = g_stg[M-1].vld_q;
  assign value_o = g_stg[M-1].res_q;

endmodule

// File: rtl/rof_checker.sv
module rof_checker import rof_pkg::*; #(
  parameter  int unsigned N  = 5,
  parameter  int unsigned M  = 8,
  localparam int unsigned KW = rank_width(N)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           valid_i,
  input logic [N*M-1:0] samples_i,
  input logic [KW-1:0]  rank_i,
  input logic           valid_o,
  input logic [M-1:0]   value_o
);
  logic [M-1:0] win_max, win_min;
  logic [M-1:0] hv;
  logic [KW-1:0] hk [M];
  logic [M-1:0] hmax [M];
  logic [M-1:0] hmin [M];

  always_comb begin
    win_max = '0;
    win_min = '1;
    for (int j = 0; j < N; j++) begin
      if (samples_i[j*M +: M] > win_max) win_max = samples_i[j*M +: M];
      if (samples_i[j*M +: M] < win_min) win_min = samples_i[j*M +: M];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hv <= '0;
    else         hv <= {hv[M-2:0], valid_i};
  end

  always_ff @(posedge clk_i) begin
    hk[0]   <= rank_i;
    hmax[0] <= win_max;
    hmin[0] <= win_min;
    for (int i = 1; i < M; i++) begin
      hk[i]   <= hk[i-1];
      hmax[i] <= hmax[i-1];
      hmin[i] <= hmin[i-1];
    end
  end

  assert_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == hv[M-1]);

  assert_bounds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && int'(hk[M-1]) >= 1 && int'(hk[M-1]) <= int'(N))
      |-> (value_o <= hmax[M-1] && value_o >= hmin[M-1]));

  assert_max_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && int'(hk[M-1]) == 1) |-> value_o == hmax[M-1]);

  assert_min_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && int'(hk[M-1]) == int'(N)) |-> value_o == hmin[M-1]);

  assert_reset_R9: assert property (@(posedge clk_i)
    !rst_ni |-> !valid_o);

  assert_rank_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && int'(hk[M-1]) == 0) |-> value_o == '1);

  assert_rank_over_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && int'(hk[M-1]) > int'(N)) |-> value_o == '0);
endmodule

bind rank_order_pipe rof_checker #(.N(N), .M(M)) i_rof_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .samples_i (samples_i),
  .rank_i    (rank_i),
  .valid_o   (valid_o),
  .value_o   (value_o)
);

// File: tb/test_rank_order_pipe.sv
module test_rank_order_pipe;
  localparam int N      = 5;
  localparam int M      = 8;
  localparam int KW     = $clog2(N + 1);
  localparam int CLK_HP = 10;  // 20 ns period, 50 MHz

  logic           clk_i = 1'b0;
  logic           rst_ni;
  logic           valid_i;
  logic [N*M-1:0] samples_i;
  logic [KW-1:0]  rank_i;
  logic           valid_o;
  logic [M-1:0]   value_o;

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_tag = "R9";
  int unsigned lcg = 32'h1234_5678;

  rank_order_pipe #(.N(N), .M(M)) i_rank_order_pipe (
    .clk_i, .rst_ni, .valid_i, .samples_i, .rank_i, .valid_o, .value_o
  );

  always #CLK_HP clk_i = ~clk_i;

  function automatic logic [M-1:0] ref_rank(input logic [N*M-1:0] s, input int k);
    int v [N];
    int t;
    if (k < 1) return '1;
    if (k > N) return '0;
    for (int j = 0; j < N; j++) v[j] = int'(s[j*M +: M]);
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N - 1 - a; b++)
        if (v[b] < v[b+1]) begin t = v[b]; v[b] = v[b+1]; v[b+1] = t; end
    return M'(v[k-1]);
  endfunction

  // Expected-output model: one slot per pipeline cycle.
  logic         mv [M];
  logic [M-1:0] md [M];
  string        mt [M];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < M; i++) begin mv[i] <= 1'b0; mt[i] <= "R9"; end
    end else begin
      mv[0] <= valid_i;
      md[0] <= ref_rank(samples_i, int'(rank_i));
      mt[0] <= cur_tag;
      for (int i = 1; i < M; i++) begin
        mv[i] <= mv[i-1]; md[i] <= md[i-1]; mt[i] <= mt[i-1];
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [M-1:0] act, input logic [M-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      check(valid_o == 1'b0, "R9", "valid during reset", M'(valid_o), '0);
    end else begin
      check(valid_o == mv[M-1], mt[M-1], "valid_o", M'(valid_o), M'(mv[M-1]));
      if (valid_o && mv[M-1])
        check(value_o == md[M-1], mt[M-1], "value_o", value_o, md[M-1]);
    end
  end

  function automatic logic [N*M-1:0] pack5(input int a, b, c, d, e);
    return {M'(e), M'(d), M'(c), M'(b), M'(a)};
  endfunction

  function automatic logic [N*M-1:0] rnd_win();
    logic [N*M-1:0] w;
    for (int j = 0; j < N; j++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      w[j*M +: M] = M'(lcg >> 16);
    end
    return w;
  endfunction

  task automatic push(input logic [N*M-1:0] w, input int k, input string tag);
    @(posedge clk_i); #2;
    cur_tag = tag; valid_i = 1'b1; samples_i = w; rank_i = KW'(k);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i); #2;
      cur_tag = tag; valid_i = 1'b0; samples_i = '0; rank_i = '0;
    end
  endtask

  task automatic test_single();  // R1, R2
    push(pack5(10, 200, 55, 200, 3), 3, "R2");
    idle(M + 2, "R1");
    push(pack5(5, 5, 9, 9, 1), 2, "R2");
    push(pack5(5, 5, 9, 9, 1), 3, "R2");
    push(pack5(77, 77, 77, 77, 77), 4, "R2");
    push(pack5(128, 127, 129, 0, 255), 2, "R2");
    idle(M + 2, "R1");
  endtask

  task automatic test_extremes();  // R3, R4, R5
    push(pack5(0, 255, 17, 240, 90), 1, "R3");
    push(pack5(0, 255, 17, 240, 90), N, "R4");
    push(pack5(0, 255, 17, 240, 90), (N + 1) / 2, "R5");
    push(pack5(3, 3, 3, 200, 200), (N + 1) / 2, "R5");
    push(pack5(255, 255, 255, 255, 254), N, "R4");
    push(pack5(0, 0, 1, 0, 0), 1, "R3");
    idle(M + 2, "R3");
  endtask

  task automatic test_stream();  // R6, R7
    for (int i = 0; i < 40; i++) push(rnd_win(), (i % N) + 1, (i % 2) ? "R6" : "R7");
    idle(M + 2, "R7");
  endtask

  task automatic test_bubbles();  // R8
    for (int i = 0; i < 12; i++) begin
      push(rnd_win(), (i % N) + 1, "R8");
      idle((i % 3) + 1, "R8");
    end
    idle(M + 2, "R8");
  endtask

  task automatic test_out_of_range();  // R10
    push(pack5(1, 2, 3, 4, 5), 0, "R10");
    push(pack5(1, 2, 3, 4, 5), 6, "R10");
    push(pack5(255, 255, 255, 255, 255), 7, "R10");
    push(pack5(0, 0, 0, 0, 0), 0, "R10");
    push(pack5(1, 2, 3, 4, 5), 1, "R10");
    idle(M + 2, "R10");
  endtask

  task automatic test_reset_midflight();  // R9
    push(rnd_win(), 1, "R9");
    push(rnd_win(), 2, "R9");
    push(rnd_win(), 3, "R9");
    @(posedge clk_i); #5;
    valid_i = 1'b0; cur_tag = "R9"; rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    #5; rst_ni = 1'b1;
    idle(M + 3, "R9");
    push(pack5(9, 8, 7, 6, 5), 2, "R9");
    idle(M + 2, "R9");
  endtask

  initial begin
    rst_ni = 1'b0; valid_i = 1'b0; samples_i = '0; rank_i = '0;
    repeat (3) @(posedge clk_i);
    #2; rst_ni = 1'b1;
    idle(2, "R9");
    test_single();
    test_extremes();
    test_stream();
    test_bubbles();
    test_out_of_range();
    test_reset_midflight();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(2 * CLK_HP * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule